// File: doc/BRIEF.md
# TDMA Schedule-Table Bus Controller

This block gives one node timed access to a shared broadcast channel that is divided into slots. A round has one slot per node, and the slot layout is the same in every round. Several rounds make up a cycle, and the cycle repeats without end. For every slot of every round, a small local descriptor table gives four things: whether the node sends or receives in that slot, the tick within the slot at which the frame starts, the address of the frame in a dual-ported message buffer, and the frame length. Because each round has its own entries, the frame contents can change from round to round while the slot timing stays the same.

In a transmit slot owned by this node, the controller reads the frame from the buffer's read port and streams it out, one byte per clock. In a receive slot, it writes the incoming bytes into the buffer through the write port. When a received frame starts, the controller compares the local tick at that moment with the tick the table expected. It uses the difference, limited to a small bound, to shift the start of the following slot, so the local time base follows the rest of the network. A one-clock interrupt pulse marks the start of every round, and a second pulse marks the start of every cycle.

The host fills the table through a simple write port, normally while reset is held. The table has no reset.

Top module: `tdma_sched_ctrl`

## Requirements
- R1: While reset is asserted, `tx_valid`, `buf_we`, `tick_irq` and `cycle_start` are all 0. After reset the controller is in round 0, slot 0, at local tick 0.
- R2: A transmit entry with length L≥1 and start tick T, in the slot that equals `own_slot`, puts the buffer bytes at addr, addr+1, …, addr+L−1 on `tx_data`, one per clock with `tx_valid` high. The first byte appears two clocks after the clock in which the local tick equals T.
- R3: A length field above 32 is treated as 32, so a transmit frame never carries more than 32 bytes.
- R4: A transmit entry in a slot other than `own_slot` produces no output.
- R5: An entry with length 0 leaves the slot idle. Nothing is transmitted, and received bytes are not written to the buffer.
- R6: In a receive slot, the byte flagged by `rx_sof` is written to the entry's address, and the following `rx_valid` bytes go to successive addresses. Each write appears on `buf_we` one clock after the byte is presented. At most the entry's length is written, and only the first start of frame in a slot is accepted.
- R7: The observed tick of an accepted start of frame, minus the entry's start tick, is limited to the range −4…+4. The next slot then begins at local tick equal to minus that value, so the slot lasts 64 plus the difference in clocks. The slot after that begins normally at tick 0.
- R8: `tick_irq` is a one-clock pulse in the first clock of every round after a wrap from the last slot. It never stays high for two clocks.
- R9: After the last slot of the last round, round and slot return to 0 and `cycle_start` pulses for one clock, together with `tick_irq`. The round-0 entries are then used again.
- R10: The table entry index is round×4+slot. The entry fields are: length in bits [5:0], buffer address in [13:6], start tick in [19:14], and direction in bit 20 (1 = transmit, 0 = receive). An entry is written when `tbl_we` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| own_slot | input | 2 | Slot index in which this node may transmit |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | 4 | Table entry index (round×4+slot) |
| tbl_wdata | input | 21 | Table entry value |
| buf_raddr | output | 8 | Message buffer read address |
| buf_rdata | input | 8 | Message buffer read data (asynchronous read) |
| buf_we | output | 1 | Message buffer write enable |
| buf_waddr | output | 8 | Message buffer write address |
| buf_wdata | output | 8 | Message buffer write data |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_sof | input | 1 | Incoming byte is the first of a frame |
| rx_data | input | 8 | Incoming byte |
| tick_irq | output | 1 | Round-start interrupt pulse |
| cycle_start | output | 1 | Cycle-start pulse |

## Verification
A wrong slot or round counter makes the wrong table entry active, so it shows at once. Either the next frame appears with the wrong bytes or at the wrong cycle, or a foreign or idle slot starts producing output, and this is seen within one slot of 64 clocks. A wrong clock correction does not change any data. It only moves the next slot boundary by a few cycles, so the check is the exact cycle of the first transmit byte and of the next round pulse after each resynchronising frame. A fault in the round wrap only appears one full cycle later, when the round-0 frame is transmitted again and `cycle_start` pulses.

// File: rtl/tdma_sched_ctrl.sv
module tdma_sched_ctrl #(
  parameter int SLOTS      = 4,
  parameter int ROUND_BITS = 2,
  parameter int SLOT_TICKS = 64,
  parameter int ADDR_W     = 8,
  parameter int MAX_LEN    = 32,
  parameter int CORR_LIM   = 4,
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int TW     = $clog2(SLOT_TICKS),
  localparam int LEN_W  = $clog2(MAX_LEN + 1),
  localparam int IDX_W  = SLOT_W + ROUND_BITS,
  localparam int ENT_W  = 1 + TW + ADDR_W + LEN_W
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] own_slot,
  input  logic              tbl_we,
  input  logic [IDX_W-1:0]  tbl_idx,
  input  logic [ENT_W-1:0]  tbl_wdata,
  output logic [ADDR_W-1:0] buf_raddr,
  input  logic [7:0]        buf_rdata,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_waddr,
  output logic [7:0]        buf_wdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  input  logic              rx_sof,
  input  logic [7:0]        rx_data,
  output logic              tick_irq,
  output logic              cycle_start
);

  localparam int DEPTH = 1 << IDX_W;
  localparam int CW    = TW + 2;
  localparam logic signed [CW-1:0] LIM_P = CW'(CORR_LIM);
  localparam logic signed [CW-1:0] LIM_N = -LIM_P;

  logic [ENT_W-1:0] tbl [DEPTH];

  always_ff @(posedge clk)
    if (tbl_we) tbl[tbl_idx] <= tbl_wdata;

  logic signed [CW-1:0]  tick, corr;
  logic [SLOT_W-1:0]     slot;
  logic [ROUND_BITS-1:0] rnd;

  logic [ENT_W-1:0] ent;
  assign ent = tbl[{rnd, slot}];

  logic              ent_tx;
  logic [TW-1:0]     ent_time;
  logic [ADDR_W-1:0] ent_addr;
  logic [LEN_W-1:0]  ent_len_raw, ent_len;

  assign ent_tx      = ent[ENT_W-1];
  assign ent_time    = ent[ENT_W-2 -: TW];
  assign ent_addr    = ent[LEN_W +: ADDR_W];
  assign ent_len_raw = ent[LEN_W-1:0];
  assign ent_len     = (ent_len_raw > LEN_W'(MAX_LEN)) ? LEN_W'(MAX_LEN) : ent_len_raw;

  logic signed [CW-1:0] sched_t, diff, corr_new;
  assign sched_t  = $signed({2'b00, ent_time});
  assign diff     = tick - sched_t;
  assign corr_new = (diff > LIM_P) ? LIM_P : (diff < LIM_N) ? LIM_N : diff;

  logic slot_end, last_slot, last_rnd, at_time;
  assign slot_end  = (tick == CW'(SLOT_TICKS - 1));
  assign last_slot = (slot == SLOT_W'(SLOTS - 1));
  assign last_rnd  = &rnd;
  assign at_time   = (tick == sched_t);

  logic tx_busy, rx_seen;
  logic [LEN_W-1:0]  tx_left, rx_left;
  logic [ADDR_W-1:0] tx_ptr, rx_ptr;

  logic rx_open, rx_start, tx_go;
  assign rx_open  = !ent_tx && (ent_len != '0);
  assign rx_start = rx_open && rx_valid && rx_sof && !rx_seen && !slot_end;
  assign tx_go    = ent_tx && (ent_len != '0) && (slot == own_slot) && at_time && !tx_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      tick        <= '0;
      corr        <= '0;
      slot        <= '0;
      rnd         <= '0;
      tick_irq    <= 1'b0;
      cycle_start <= 1'b0;
    end else begin
      tick_irq    <= 1'b0;
      cycle_start <= 1'b0;
      if (slot_end) begin
        tick <= -corr;
        corr <= '0;
        if (last_slot) begin
          slot        <= '0;
          rnd         <= rnd + ROUND_BITS'(1);
          tick_irq    <= 1'b1;
          cycle_start <= last_rnd;
        end else begin
          slot <= slot + SLOT_W'(1);
        end
      end else begin
        tick <= tick + CW'(1);
        if (rx_start) corr <= corr_new;
      end
    end
  end

  assign buf_raddr = tx_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_busy  <= 1'b0;
      tx_left  <= '0;
      tx_ptr   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= tx_busy;
      if (tx_busy) begin
        tx_data <= buf_rdata;
        tx_ptr  <= tx_ptr + ADDR_W'(1);
        tx_left <= tx_left - LEN_W'(1);
        if (tx_left == LEN_W'(1)) tx_busy <= 1'b0;
      end else if (tx_go) begin
        tx_busy <= 1'b1;
        tx_ptr  <= ent_addr;
        tx_left <= ent_len;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_seen   <= 1'b0;
      rx_left   <= '0;
      rx_ptr    <= '0;
      buf_we    <= 1'b0;
      buf_waddr <= '0;
      buf_wdata <= '0;
    end else begin
      buf_we <= 1'b0;
      if (slot_end) begin
        rx_seen <= 1'b0;
        rx_left <= '0;
      end else if (rx_start) begin
        buf_we    <= 1'b1;
        buf_waddr <= ent_addr;
        buf_wdata <= rx_data;
        rx_ptr    <= ent_addr + ADDR_W'(1);
        rx_left   <= ent_len - LEN_W'(1);
        rx_seen   <= 1'b1;
      end else if (rx_valid && !rx_sof && (rx_left != '0)) begin
        buf_we    <= 1'b1;
        buf_waddr <= rx_ptr;
        buf_wdata <= rx_data;
        rx_ptr    <= rx_ptr + ADDR_W'(1);
        rx_left   <= rx_left - LEN_W'(1);
      end
    end
  end

endmodule

// File: rtl/tdma_sched_ctrl_chk.sv
module tdma_sched_ctrl_chk #(
  parameter int CW       = 8,
  parameter int MAX_LEN  = 32,
  parameter int CORR_LIM = 4
)(
  input logic                 clk,
  input logic                 rst,
  input logic                 tick_irq,
  input logic                 cycle_start,
  input logic                 tx_valid,
  input logic                 buf_we,
  input logic                 rx_valid,
  input logic signed [CW-1:0] corr
);

  localparam logic signed [CW-1:0] LIM = CW'(CORR_LIM);

  logic [15:0] run;
  always_ff @(posedge clk)
    if (rst) run <= '0;
    else     run <= tx_valid ? run + 16'd1 : 16'd0;

  a_r3_burst_limit: assert property (@(posedge clk) disable iff (rst)
    run <= 16'(MAX_LEN));

  a_r7_corr_bounded: assert property (@(posedge clk) disable iff (rst)
    (corr <= LIM) && (corr >= -LIM));

  a_r8_irq_one_clock: assert property (@(posedge clk) disable iff (rst)
    tick_irq |=> !tick_irq);

  a_r9_cycle_start_with_irq: assert property (@(posedge clk) disable iff (rst)
    cycle_start |-> tick_irq);

  a_r6_write_follows_rx: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> $past(rx_valid));

endmodule

bind tdma_sched_ctrl tdma_sched_ctrl_chk #(
  .CW(CW), .MAX_LEN(MAX_LEN), .CORR_LIM(CORR_LIM)
) u_chk (
  .clk(clk), .rst(rst), .tick_irq(tick_irq), .cycle_start(cycle_start),
  .tx_valid(tx_valid), .buf_we(buf_we), .rx_valid(rx_valid), .corr(corr)
);

// File: tb/test_tdma_sched_ctrl.sv
`timescale 1ns/1ps
module test_tdma_sched_ctrl;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  own_slot = 2'd1;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_idx = '0;
  logic [20:0] tbl_wdata = '0;
  logic [7:0]  buf_raddr, buf_rdata, buf_waddr, buf_wdata;
  logic        buf_we, tx_valid;
  logic [7:0]  tx_data;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        tick_irq, cycle_start;

  tdma_sched_ctrl i_tdma_sched_ctrl (
    .clk(clk), .rst(rst), .own_slot(own_slot),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
    .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
    .tx_valid(tx_valid), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_data(rx_data),
    .tick_irq(tick_irq), .cycle_start(cycle_start)
  );

  logic [7:0] mem [256];
  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i * 7 + 3);
  always @(posedge clk) if (buf_we) mem[buf_waddr] <= buf_wdata;
  assign buf_rdata = mem[buf_raddr];

  int cyc;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct { int at; logic [7:0] a; logic [7:0] d; string req; } exp_t;
  exp_t tx_q[$];
  exp_t wr_q[$];

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R10: {dir[20], start tick[19:14], address[13:6], length[5:0]}
  function automatic logic [20:0] ent(bit tx, int t, int a, int l);
    return {tx, 6'(t), 8'(a), 6'(l)};
  endfunction

  task automatic put_ent(int idx, logic [20:0] w);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 4'(idx); tbl_wdata = w;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic expect_tx(int at, int a, int n, string req);
    for (int i = 0; i < n; i++)
      tx_q.push_back('{at + i, 8'(a + i), 8'((a + i) * 7 + 3), req});
  endtask

  task automatic send_rx(int at, int n, logic [7:0] base, int a, int keep, string req);
    for (int i = 0; i < keep; i++)
      wr_q.push_back('{at + 1 + i, 8'(a + i), base + 8'(i), req});
    while (cyc != at) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_sof = (i == 0); rx_data = base + 8'(i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      if (tx_valid) begin
        if (tx_q.size() == 0) check(1'b0, "R4", "unexpected tx byte at cycle", cyc, -1);
        else begin
          exp_t e;
          e = tx_q.pop_front();
          check(cyc == e.at, e.req, "tx byte cycle", cyc, e.at);
          check(tx_data == e.d, e.req, "tx byte value", tx_data, e.d);
        end
      end
      if (buf_we) begin
        if (wr_q.size() == 0) check(1'b0, "R5", "unexpected buffer write at cycle", cyc, -1);
        else begin
          exp_t w;
          w = wr_q.pop_front();
          check(cyc == w.at, w.req, "write cycle", cyc, w.at);
          check(buf_waddr == w.a, w.req, "write address", buf_waddr, w.a);
          check(buf_wdata == w.d, w.req, "write data", buf_wdata, w.d);
        end
      end
      begin
        bit e_irq, e_cs;
        // round starts: 256, 513 (after -3 then clamped +4 corrections, R7), 769, 1025
        e_irq = (cyc == 256) || (cyc == 513) || (cyc == 769) || (cyc == 1025);
        e_cs  = (cyc == 1025);
        if (e_irq || tick_irq) check(tick_irq == e_irq, "R8", "tick_irq", tick_irq, e_irq);
        if (e_cs || cycle_start) check(cycle_start == e_cs, "R9", "cycle_start", cycle_start, e_cs);
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check(tx_valid == 1'b0, "R1", "tx_valid in reset", tx_valid, 0);
    check(buf_we == 1'b0, "R1", "buf_we in reset", buf_we, 0);
    check(tick_irq == 1'b0, "R1", "tick_irq in reset", tick_irq, 0);
    check(cycle_start == 1'b0, "R1", "cycle_start in reset", cycle_start, 0);

    for (int k = 0; k < 16; k++) put_ent(k, ent(0, 0, 0, 0));
    put_ent(0,  ent(0, 10, 'h40, 3));
    put_ent(1,  ent(1, 5,  'h10, 4));
    put_ent(2,  ent(1, 6,  'h00, 2));
    put_ent(4,  ent(0, 20, 'h50, 2));
    put_ent(5,  ent(1, 3,  'h20, 40));
    put_ent(6,  ent(0, 8,  'h60, 3));
    put_ent(8,  ent(0, 12, 'h70, 2));
    put_ent(9,  ent(1, 7,  'h90, 0));
    put_ent(13, ent(1, 0,  'h80, 1));

    expect_tx(71,   'h10, 4,  "R2 R10");
    expect_tx(322,  'h20, 32, "R3 R7");
    expect_tx(835,  'h80, 1,  "R2 R7");
    expect_tx(1096, 'h10, 4,  "R9");

    @(negedge clk);
    rst = 1'b0;

    send_rx(10,  3, 8'hA0, 'h40, 3, "R6");
    send_rx(200, 2, 8'hE0, 'h00, 0, "R5");
    send_rx(273, 2, 8'hB0, 'h50, 2, "R6 R7");
    send_rx(396, 3, 8'hC0, 'h60, 3, "R6 R7");
    send_rx(525, 4, 8'hD0, 'h70, 2, "R6");

    while (cyc != 1110) @(negedge clk);
    check(tx_q.size() == 0, "R2", "tx bytes still expected", tx_q.size(), 0);
    check(wr_q.size() == 0, "R6", "writes still expected", wr_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL R9 watchdog expired: actual cycle %0d expected 1110", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule